// File: doc/BRIEF.md
# Prioritized vectored interrupt controller

This block gathers sixteen interrupt sources into one interrupt request line for a CPU that reads a vector byte on acknowledge. Eight sources come from general-purpose pins, each detected on an edge the software selects per pin. The other eight come from on-chip units (four timers, receive full, receive error, transmit empty, transmit error), which pulse a request input. Every source has a fixed rank. Its state is kept in byte-wide bank registers: bank A holds the upper eight ranks and bank B the lower eight, so bit k of bank A is source code 8+k and bit k of bank B is source code k.

A source becomes pending only while its enable bit is set. It raises the interrupt output only while its mask bit is set. When the CPU acknowledges, the highest-ranked eligible source is served. Its pending bit is cleared. If nested tracking is on, its in-service bit is set, and that bit holds off the source and every source of lower rank until software clears it. The CPU bus is a plain write strobe and read strobe with a 4-bit address. Read data is registered.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0x00 and `irq` is low.
- R2: Addresses: 0 pending A, 1 pending B, 2 mask A, 3 mask B, 4 enable A, 5 enable B, 6 in-service A, 7 in-service B, 8 pin edge select, 9 control. Other addresses read 0x00. Mask, enable, edge select and control read back what was written. `rdata` shows the addressed register one cycle after `rd_en`.
- R3: A write to a pending or in-service register clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R4: A source whose enable bit is 0 never becomes pending. Writing 0 to an enable bit clears that source's pending bit on the same edge.
- R5: `irq` is high only when some source is pending and unmasked (mask bit 1) and is not held off by in-service. A masked source stays pending.
- R6: Priority is fixed by source code, with 15 highest and 0 lowest, where the code is {bank A, bank B} bit index.
- R7: `vec` = {control[7:5], winning code[3:0], 1'b0}.
- R8: An acknowledge (`iack` high while `irq` is high) clears the winner's pending bit. When control bit 3 is 1, it also sets the winner's in-service bit. While set, that bit holds off that source and all lower codes, and higher codes still interrupt. An acknowledge while `irq` is low changes nothing.
- R9: When control bit 3 is 0, the in-service registers read 0. Writing the bit to 0 clears them.
- R10: Pin p maps to code p for p=0..3, 6 for pin 4, 7 for pin 5, 14 for pin 6 and 15 for pin 7. The edge-select bit p = 1 selects a rising edge and 0 selects a falling edge. The other edge is ignored. A pin edge reaches pending SYNC_STAGES+1 clock edges after the pin changes.
- R11: `unit_evt` bits 0..7 request codes 8 (timer B), 9 (Tx error), 10 (Tx empty), 11 (Rx error), 12 (Rx full), 13 (timer A), 4 (timer D) and 5 (timer C).
- R12: A request arriving on the same edge as an acknowledge or a write-clear of the same source leaves the source pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| gpio_in | input | 8 | General-purpose pin inputs |
| unit_evt | input | 8 | On-chip unit request pulses |
| iack | input | 1 | Interrupt acknowledge |
| irq | output | 1 | Interrupt request, active high |
| vec | output | 8 | Vector for the current winner |

## Verification
Serving a source and a new request from that same source can land on one clock edge. The same holds for a software clear of its pending bit and a new request. The bench provokes both by pulsing a unit request input in the very cycle that `iack` or the pending-register write is applied. It then judges the result by reading the pending register back, where the bit must still be set. Nested service is judged by `irq` and `vec` while in-service bits are set and cleared one at a time.

// File: rtl/vic_pkg.sv
package vic_pkg;
   localparam int DW     = 8;
   localparam int AW     = 4;
   localparam int NSRC   = 2 * DW;
   localparam int CODE_W = $clog2(NSRC);
   localparam int VB_W   = DW - CODE_W - 1;

   typedef enum logic [AW-1:0] {
      RA_PEND_A = 4'd0, RA_PEND_B = 4'd1,
      RA_MASK_A = 4'd2, RA_MASK_B = 4'd3,
      RA_EN_A   = 4'd4, RA_EN_B   = 4'd5,
      RA_ISV_A  = 4'd6, RA_ISV_B  = 4'd7,
      RA_EDGE   = 4'd8, RA_CTRL   = 4'd9
   } reg_addr_e;

   localparam int CTRL_ISE_BIT = 3;

   // rank of each general-purpose pin
   function automatic logic [CODE_W-1:0] pin_code(input int p);
      case (p)
         4:       return CODE_W'(6);
         5:       return CODE_W'(7);
         6:       return CODE_W'(14);
         7:       return CODE_W'(15);
         default: return CODE_W'(p);
      endcase
   endfunction

   // rank of each on-chip unit request
   function automatic logic [CODE_W-1:0] unit_code(input int u);
      case (u)
         6:       return CODE_W'(4);
         7:       return CODE_W'(5);
         default: return CODE_W'(8 + u);
      endcase
   endfunction
endpackage

// File: rtl/vic_edge_detect.sv
module vic_edge_detect #(
   parameter int W           = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pin_i,
   input  logic [W-1:0] rise_sel_i,
   output logic [W-1:0] edge_o
);
   logic [W-1:0] cur;
   logic [W-1:0] prev_q;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign cur = pin_i;
      end else begin : g_sync
         logic [W-1:0] sync_q [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
            end else begin
               sync_q[0] <= pin_i;
               for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
            end
         end
         assign cur = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= cur;
   end

   assign edge_o = (rise_sel_i & cur & ~prev_q) | (~rise_sel_i & ~cur & prev_q);
endmodule

// File: rtl/vic_prio_resolve.sv
module vic_prio_resolve #(
   parameter int N  = 16,
   parameter int CW = $clog2(N)
) (
   input  logic [N-1:0]  req_i,
   input  logic [N-1:0]  isv_i,
   output logic          any_o,
   output logic [CW-1:0] code_o
);
   logic [N-1:0] elig;

   always_comb begin
      logic held;
      held = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         held    = held | isv_i[i];
         elig[i] = req_i[i] & ~held;
      end
      code_o = '0;
      for (int i = 0; i < N; i++) begin
         if (elig[i]) code_o = CW'(i);
      end
   end

   assign any_o = |elig;
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
   import vic_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          rd_en,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   input  logic [DW-1:0] gpio_in,
   input  logic [DW-1:0] unit_evt,
   input  logic          iack,
   output logic          irq,
   output logic [DW-1:0] vec
);
   generate
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0..4");
      end
      if (NSRC != 2 * DW) begin : g_bad_banks
         $error("two banks must cover every source");
      end
   endgenerate

   logic [NSRC-1:0]   pend_q, mask_q, en_q, isv_q;
   logic [NSRC-1:0]   pend_n, mask_n, en_n, isv_n;
   logic [DW-1:0]     edge_q, edge_n, ctrl_q, ctrl_n;
   logic [NSRC-1:0]   pend_keep, isv_keep, req_set, ack_clr;
   logic [DW-1:0]     pin_edge;
   logic [DW-1:0]     rdata_q;
   logic              win_any, ack_go, ise_on;
   logic [CODE_W-1:0] win_code;

   assign ise_on = ctrl_q[CTRL_ISE_BIT];

   vic_edge_detect #(.W(DW), .SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_i     (gpio_in),
      .rise_sel_i(edge_q),
      .edge_o    (pin_edge)
   );

   // route pins and unit pulses onto their ranks
   always_comb begin
      req_set = '0;
      for (int p = 0; p < DW; p++) req_set[pin_code(p)] = req_set[pin_code(p)] | pin_edge[p];
      for (int u = 0; u < DW; u++) req_set[unit_code(u)] = req_set[unit_code(u)] | unit_evt[u];
   end

   vic_prio_resolve #(.N(NSRC), .CW(CODE_W)) u_prio (
      .req_i (pend_q & mask_q),
      .isv_i (isv_q),
      .any_o (win_any),
      .code_o(win_code)
   );

   assign ack_go  = iack & win_any;
   assign ack_clr = ack_go ? (NSRC'(1) << win_code) : '0;

   // register writes
   always_comb begin
      mask_n    = mask_q;
      en_n      = en_q;
      edge_n    = edge_q;
      ctrl_n    = ctrl_q;
      pend_keep = '1;
      isv_keep  = '1;
      if (wr_en) begin
         case (addr)
            RA_PEND_A: pend_keep[NSRC-1:DW] = wdata;
            RA_PEND_B: pend_keep[DW-1:0]    = wdata;
            RA_MASK_A: mask_n[NSRC-1:DW]    = wdata;
            RA_MASK_B: mask_n[DW-1:0]       = wdata;
            RA_EN_A:   en_n[NSRC-1:DW]      = wdata;
            RA_EN_B:   en_n[DW-1:0]         = wdata;
            RA_ISV_A:  isv_keep[NSRC-1:DW]  = wdata;
            RA_ISV_B:  isv_keep[DW-1:0]     = wdata;
            RA_EDGE:   edge_n               = wdata;
            RA_CTRL:   ctrl_n               = wdata;
            default: ;
         endcase
      end
      // a new request outranks any clear on the same edge
      pend_n = ((pend_q & pend_keep & ~ack_clr) | req_set) & en_n;
      if (ctrl_n[CTRL_ISE_BIT])
         isv_n = (isv_q & isv_keep) | (ise_on ? ack_clr : '0);
      else
         isv_n = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         mask_q <= '0;
         en_q   <= '0;
         isv_q  <= '0;
         edge_q <= '0;
         ctrl_q <= '0;
      end else begin
         pend_q <= pend_n;
         mask_q <= mask_n;
         en_q   <= en_n;
         isv_q  <= isv_n;
         edge_q <= edge_n;
         ctrl_q <= ctrl_n;
      end
   end

   // registered read port
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (rd_en) begin
         case (addr)
            RA_PEND_A: rdata_q <= pend_q[NSRC-1:DW];
            RA_PEND_B: rdata_q <= pend_q[DW-1:0];
            RA_MASK_A: rdata_q <= mask_q[NSRC-1:DW];
            RA_MASK_B: rdata_q <= mask_q[DW-1:0];
            RA_EN_A:   rdata_q <= en_q[NSRC-1:DW];
            RA_EN_B:   rdata_q <= en_q[DW-1:0];
            RA_ISV_A:  rdata_q <= isv_q[NSRC-1:DW];
            RA_ISV_B:  rdata_q <= isv_q[DW-1:0];
            RA_EDGE:   rdata_q <= edge_q;
            RA_CTRL:   rdata_q <= ctrl_q;
            default:   rdata_q <= '0;
         endcase
      end
   end

   assign rdata = rdata_q;
   assign irq   = win_any;
   assign vec   = {ctrl_q[DW-1 -: VB_W], win_code, 1'b0};
endmodule

// File: rtl/vic_sva.sv
module vic_sva #(
   parameter int N  = 16,
   parameter int CW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          iack,
   input logic          irq,
   input logic          wr_en,
   input logic [N-1:0]  pend,
   input logic [N-1:0]  mask,
   input logic [N-1:0]  en,
   input logic [N-1:0]  isv,
   input logic          ise,
   input logic [CW-1:0] code
);
   p_irq_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((pend & mask) != '0));

   p_enable_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pend & ~en) == '0);

   p_isv_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !ise |-> (isv == '0));

   p_ack_sets_isv_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (iack && irq && ise && !wr_en) |=> isv[$past(code)]);

   p_winner_not_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> !isv[code]);
endmodule

bind vec_irq_ctrl vic_sva #(.N(vic_pkg::NSRC), .CW(vic_pkg::CODE_W)) u_vic_sva (
   .clk  (clk),
   .rst_n(rst_n),
   .iack (iack),
   .irq  (irq),
   .wr_en(wr_en),
   .pend (pend_q),
   .mask (mask_q),
   .en   (en_q),
   .isv  (isv_q),
   .ise  (ise_on),
   .code (win_code)
);

// File: tb/test_vec_irq_ctrl.sv
module test_vec_irq_ctrl;
   logic       clk = 0, rst_n = 0;
   logic       wr_en = 0, rd_en = 0, iack = 0;
   logic [3:0] addr = 0;
   logic [7:0] wdata = 0, gpio_in = 0, unit_evt = 0;
   logic [7:0] rdata, vec;
   logic       irq;
   logic       rd_q = 0;
   int         checks = 0, errors = 0;
   bit         done = 0;

   typedef struct { logic [7:0] exp; string tag; } item_t;
   item_t sbq[$];

   always #10 clk = ~clk;

   vec_irq_ctrl i_vec_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .gpio_in(gpio_in), .unit_evt(unit_evt),
      .iack(iack), .irq(irq), .vec(vec)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops expected read data
   always @(posedge clk) rd_q <= rd_en;
   always @(negedge clk) begin
      if (rd_q) begin
         if (sbq.size() == 0) begin
            chk("scoreboard underflow", 8'h01, 8'h00);
         end else begin
            item_t it;
            it = sbq.pop_front();
            chk(it.tag, rdata, it.exp);
         end
      end
   end

   // one bus cycle with optional write, acknowledge and unit pulse
   task automatic cyc(input logic w, input logic [3:0] a, input logic [7:0] d,
                      input logic ak, input logic [7:0] ev);
      @(negedge clk);
      wr_en = w; addr = a; wdata = d; iack = ak; unit_evt = ev;
      @(negedge clk);
      wr_en = 0; iack = 0; unit_evt = 0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      cyc(1, a, d, 0, 8'h00);
   endtask

   task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
      item_t it;
      @(negedge clk);
      addr = a; rd_en = 1;
      it.exp = exp; it.tag = tag;
      sbq.push_back(it);
      @(negedge clk);
      rd_en = 0;
   endtask

   task automatic pulse(input int u);
      cyc(0, 0, 0, 0, 8'h01 << u);
   endtask

   task automatic ack();
      cyc(0, 0, 0, 1, 8'h00);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 irq after reset", {7'd0, irq}, 8'h00);
      rd(0, 8'h00, "R1 pend A reset");
      rd(1, 8'h00, "R1 pend B reset");
      rd(2, 8'h00, "R1 mask A reset");
      rd(9, 8'h00, "R1 ctrl reset");

      wr(2, 8'hFF); wr(3, 8'hFF);
      pulse(5);
      rd(0, 8'h00, "R4 disabled source not pending");
      wr(4, 8'hFF); wr(5, 8'hFF);
      rd(4, 8'hFF, "R2 enable A readback");
      wr(8, 8'h5A);
      rd(8, 8'h5A, "R2 edge readback");
      wr(9, 8'hA0);
      rd(9, 8'hA0, "R2 ctrl readback");
      rd(12, 8'h00, "R2 unused address");

      pulse(5);
      rd(0, 8'h20, "R11 timer A to code 13");
      chk("R5 irq with pending", {7'd0, irq}, 8'h01);
      chk("R7 vector code 13", vec, 8'hBA);
      wr(2, 8'hDF);
      chk("R5 masked no irq", {7'd0, irq}, 8'h00);
      rd(0, 8'h20, "R5 masked stays pending");
      wr(2, 8'hFF);

      pulse(6);
      rd(1, 8'h10, "R11 timer D to code 4");
      chk("R6 higher code wins", vec, 8'hBA);
      wr(0, 8'hDF);
      rd(0, 8'h00, "R3 write zero clears");
      wr(1, 8'hFF);
      rd(1, 8'h10, "R3 write one keeps");
      chk("R7 vector code 4", vec, 8'hA8);
      ack();
      rd(1, 8'h00, "R8 ack clears pending");
      rd(7, 8'h00, "R9 no in-service when off");
      chk("R8 irq low after ack", {7'd0, irq}, 8'h00);

      pulse(7);
      rd(1, 8'h20, "R11 timer C to code 5");
      wr(5, 8'hDF);
      rd(1, 8'h00, "R4 disable clears pending");
      wr(5, 8'hFF);

      wr(8, 8'h80);
      @(negedge clk); gpio_in = 8'h81;
      repeat (5) @(negedge clk);
      rd(0, 8'h80, "R10 pin 7 rising to code 15");
      rd(1, 8'h00, "R10 pin 0 rising ignored");
      wr(0, 8'h00);
      chk("R10 irq idle", {7'd0, irq}, 8'h00);
      @(negedge clk); gpio_in = 8'h80;
      @(posedge clk); @(posedge clk); @(negedge clk);
      chk("R10 not yet pending", {7'd0, irq}, 8'h00);
      @(posedge clk); @(negedge clk);
      chk("R10 falling edge latency", {7'd0, irq}, 8'h01);
      chk("R10 pin 0 code 0 vector", vec, 8'hA0);
      wr(1, 8'h00);
      @(negedge clk); gpio_in = 8'h00;
      repeat (5) @(negedge clk);
      rd(0, 8'h00, "R10 pin 7 falling ignored");

      wr(9, 8'hA8);
      pulse(0);
      ack();
      rd(6, 8'h01, "R8 in-service set");
      rd(0, 8'h00, "R8 pending cleared");
      pulse(6);
      chk("R8 lower held off", {7'd0, irq}, 8'h00);
      pulse(0);
      chk("R8 same source held off", {7'd0, irq}, 8'h00);
      pulse(5);
      chk("R8 higher interrupts", {7'd0, irq}, 8'h01);
      chk("R8 higher vector", vec, 8'hBA);
      ack();
      rd(6, 8'h21, "R8 nested in-service");
      chk("R8 nested held", {7'd0, irq}, 8'h00);
      wr(6, 8'hDF);
      rd(6, 8'h01, "R3 in-service write zero");
      chk("R8 still held", {7'd0, irq}, 8'h00);
      wr(6, 8'h00);
      chk("R8 released", vec, 8'hB0);
      ack();
      wr(9, 8'hA0);
      rd(6, 8'h00, "R9 off clears in-service");
      chk("R9 timer D now wins", vec, 8'hA8);

      cyc(0, 0, 0, 1, 8'h40);
      rd(1, 8'h10, "R12 request beats ack");
      cyc(1, 1, 8'h00, 0, 8'h40);
      rd(1, 8'h10, "R12 request beats write clear");
      wr(1, 8'h00);
      ack();
      rd(1, 8'h00, "R8 idle ack no change");
      rd(7, 8'h00, "R8 idle ack no in-service");

      repeat (3) @(negedge clk);
      if (sbq.size() != 0) chk("scoreboard leftover", 8'(sbq.size()), 8'h00);
      done = 1;
      summary();
      $finish;
   end
endmodule